// File: doc/BRIEF.md
# Video Crosspoint Programming Register

This block is the digital control front end of a 16-input, 8-output video crosspoint. A host loads a new routing either as an 80-bit serial frame or one output at a time as a 3-bit address plus a 5-bit field. The new routing is held in a pending store. It reaches the eight output-enable flags and eight 4-bit input selects only when an update strobe falls. Because the serial chain's far end is brought out, several devices can be chained and loaded with one long stream.

Every external pin is sampled by a faster system clock through a two-flop synchronizer. Each falling edge of a sampled strobe triggers exactly one action. An active-low chip enable gates all actions. Reset returns every output to the disabled state.

Top module: `xpt_prog_reg`

## Requirements
- R1: While `rst_ni` is low, and after it rises, all bits of `out_en_o` and `in_sel_o` are 0 and `sdo_o` is 0. Reset clears both the pending and the active configuration.
- R2: With `par_mode_i` low and `ce_ni` low, each falling edge of the sampled `sclk_i` shifts the sampled `sdi_i` into the 80-bit chain.
- R3: `sdo_o` shows the far end of the chain, which is the bit shifted in 80 shift edges earlier. It shows 0 while fewer than 80 bits have entered since reset.
- R4: In a serial frame, the first 40 bits form eight 5-bit fields for outputs 7, 6 and so on down to 0. Each field starts with its enable bit (1 = enabled), followed by a 4-bit input select sent MSB first. Output k's select appears at `in_sel_o[4k+3:4k]` and its enable at `out_en_o[k]`.
- R5: The last 40 bits of a frame pass through the chain but have no effect on the outputs.
- R6: The outputs change only on a falling edge of the sampled `upd_i` while enabled. On that edge they take the pending configuration. Shifting a frame alone leaves them unchanged.
- R7: With `par_mode_i` high and `ce_ni` low, a falling edge of `sclk_i` writes `data_i` into the pending field of output `addr_i`. `data_i[4]` is the enable and `data_i[3:0]` is the select. Other outputs' pending fields are not changed.
- R8: While `ce_ni` is high, shift, parallel write and update edges have no effect. `sdo_o` still shows the chain end.
- R9: Rising edges of `sclk_i` and `upd_i` cause no action. Holding a strobe low causes no further action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Shift / load clock pin, acts on falling edge |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, far end of chain |
| upd_i | input | 1 | Update strobe, acts on falling edge |
| ce_ni | input | 1 | Chip enable, active low |
| par_mode_i | input | 1 | 0 = serial, 1 = parallel load |
| addr_i | input | 3 | Output address for parallel load |
| data_i | input | 5 | Field for parallel load: enable, then select |
| out_en_o | output | 8 | Active output enables |
| in_sel_o | output | 32 | Active input selects, 4 bits per output |

## Verification
The first serial frame has mixed enables, distinct selects and zero padding. Checks before and after the update show whether the outputs wait for the strobe and whether fields land on the right outputs in the right bit order. A second frame uses nonzero padding, which shows whether the trailing half leaks into the outputs. Sampling `sdo_o` during each frame confirms the 80-bit chain length.

A single parallel write to one address shows whether the write stays inside that one field. Strobes sent with the device disabled, strobes held low and rising strobe edges each check that the only action is one per enabled falling edge.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int NUM_OUT   = 8;
  localparam int SEL_W     = 4;
  localparam int FIELD_W   = SEL_W + 1;
  localparam int ADDR_W    = $clog2(NUM_OUT);
  localparam int CHAIN_LEN = 80;
  localparam int CFG_W     = NUM_OUT * FIELD_W;
  localparam int PAD_W     = CHAIN_LEN - CFG_W;
  localparam int SYNC_W    = 2 + ADDR_W + FIELD_W;
endpackage

// File: rtl/xpt_pin_sync.sv
module xpt_pin_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xpt_chain.sv
module xpt_chain
  import xpt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               din_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               sdo_o,
  output logic [CFG_W-1:0]   pend_o
);
  logic [CHAIN_LEN-1:0] chain_q;
  logic [PAD_W-1:0]     pad_q;
  logic [CFG_W-1:0]     cfg_q;

  // Config half sits at the far end so the first frame bits land there.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_q <= '0;
    end else if (shift_i) begin
      pad_q <= {pad_q[PAD_W-2:0], din_i};
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_field
    logic [FIELD_W-1:0] nxt;
    always_comb begin
      if (k == 0) nxt = {cfg_q[FIELD_W-2:0], pad_q[PAD_W-1]};
      else        nxt = {cfg_q[k*FIELD_W +: FIELD_W-1], cfg_q[k*FIELD_W-1]};
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[k*FIELD_W +: FIELD_W] <= '0;
      end else if (shift_i) begin
        cfg_q[k*FIELD_W +: FIELD_W] <= nxt;
      end else if (wr_i && addr_i == ADDR_W'(k)) begin
        cfg_q[k*FIELD_W +: FIELD_W] <= field_i;
      end
    end
  end

  assign chain_q = {cfg_q, pad_q};
  assign sdo_o   = chain_q[CHAIN_LEN-1];
  assign pend_o  = cfg_q;

  assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> chain_q[0] == $past(din_i) &&
                chain_q[CHAIN_LEN-1:1] == $past(chain_q[CHAIN_LEN-2:0]));
  assert_wr_keeps_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !shift_i) |=> pad_q == $past(pad_q) && $countones(cfg_q ^ $past(cfg_q)) <= FIELD_W);
  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !shift_i) |=> $stable(chain_q));
endmodule

// File: rtl/xpt_active.sv
module xpt_active
  import xpt_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [CFG_W-1:0]         pend_i,
  output logic [NUM_OUT-1:0]       en_o,
  output logic [NUM_OUT*SEL_W-1:0] sel_o
);
  logic [CFG_W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= pend_i;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    assign en_o[k]                 = act_q[k*FIELD_W + SEL_W];
    assign sel_o[k*SEL_W +: SEL_W] = act_q[k*FIELD_W +: SEL_W];
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> act_q == $past(pend_i));
endmodule

// File: rtl/xpt_prog_reg.sv
module xpt_prog_reg
  import xpt_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  input  logic                     upd_i,
  input  logic                     ce_ni,
  input  logic                     par_mode_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [FIELD_W-1:0]       data_i,
  output logic [NUM_OUT-1:0]       out_en_o,
  output logic [NUM_OUT*SEL_W-1:0] in_sel_o
);
  logic [1:0]         strb_s;
  logic [1:0]         strb_prev_q;
  logic               ce_n_s;
  logic [SYNC_W-1:0]  dat_s;
  logic               sclk_fall, upd_fall, ce_act;
  logic               shift_en, wr_en, load_en;
  logic               mode_s, din_s;
  logic [ADDR_W-1:0]  addr_s;
  logic [FIELD_W-1:0] field_s;
  logic [CFG_W-1:0]   pend;

  xpt_pin_sync #(.W(2), .RST_VAL(2'b00)) u_sync_strb (
    .clk_i, .rst_ni, .pin_i({upd_i, sclk_i}), .q_o(strb_s));
  xpt_pin_sync #(.W(1), .RST_VAL(1'b1)) u_sync_ce (
    .clk_i, .rst_ni, .pin_i(ce_ni), .q_o(ce_n_s));
  xpt_pin_sync #(.W(SYNC_W), .RST_VAL('0)) u_sync_dat (
    .clk_i, .rst_ni, .pin_i({par_mode_i, sdi_i, addr_i, data_i}), .q_o(dat_s));

  assign {mode_s, din_s, addr_s, field_s} = dat_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_prev_q <= '0;
    else         strb_prev_q <= strb_s;
  end

  assign sclk_fall = strb_prev_q[0] & ~strb_s[0];
  assign upd_fall  = strb_prev_q[1] & ~strb_s[1];
  assign ce_act    = ~ce_n_s;
  assign shift_en  = sclk_fall & ce_act & ~mode_s;
  assign wr_en     = sclk_fall & ce_act &  mode_s;
  assign load_en   = upd_fall  & ce_act;

  xpt_chain u_chain (
    .clk_i, .rst_ni,
    .shift_i(shift_en), .din_i(din_s),
    .wr_i(wr_en), .addr_i(addr_s), .field_i(field_s),
    .sdo_o, .pend_o(pend));

  xpt_active u_active (
    .clk_i, .rst_ni, .load_i(load_en), .pend_i(pend),
    .en_o(out_en_o), .sel_o(in_sel_o));

  assert_ce_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_s |=> $stable(out_en_o) && $stable(in_sel_o) && $stable(pend));
  assert_one_action_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall |=> !sclk_fall);
endmodule

// File: tb/tb_xpt_prog_reg.sv
module tb_xpt_prog_reg;
  logic        clk = 0, rst_ni = 0;
  logic        sclk = 1, sdi = 0, upd = 1, ce_n = 1, par = 0;
  logic [2:0]  addr = 0;
  logic [4:0]  data = 0;
  logic        sdo;
  logic [7:0]  en;
  logic [31:0] sel;

  always #5 clk = ~clk;

  xpt_prog_reg dut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
    .upd_i(upd), .ce_ni(ce_n), .par_mode_i(par), .addr_i(addr),
    .data_i(data), .out_en_o(en), .in_sel_o(sel));

  typedef struct packed { logic [7:0] en; logic [31:0] sel; logic sdo; } exp_t;
  exp_t  q_exp[$];
  string q_req[$];
  int    checks = 0, errors = 0;
  bit    done = 0;

  logic [79:0] m_chain = '0;
  logic [39:0] m_act   = '0;

  task automatic idle(int n); repeat (n) @(posedge clk); endtask

  task automatic push(string r);
    exp_t e;
    for (int k = 0; k < 8; k++) begin
      e.en[k]        = m_act[5*k+4];
      e.sel[4*k +: 4] = m_act[5*k +: 4];
    end
    e.sdo = m_chain[79];
    q_exp.push_back(e);
    q_req.push_back(r);
    idle(3);
  endtask

  task automatic pulse_sclk();
    idle(4); sclk = 0; idle(4); sclk = 1; idle(4);
  endtask

  task automatic shift_bit(logic b);
    par = 0; sdi = b;
    pulse_sclk();
    if (!ce_n) m_chain = {m_chain[78:0], b};
  endtask

  task automatic par_write(logic [2:0] a, logic [4:0] d);
    par = 1; addr = a; data = d;
    pulse_sclk();
    if (!ce_n) m_chain[40+5*a +: 5] = d;
    par = 0; idle(4);
  endtask

  task automatic upd_fall();
    upd = 0; idle(5);
    if (!ce_n) m_act = m_chain[79:40];
  endtask

  task automatic upd_rise(); upd = 1; idle(5); endtask

  task automatic send_frame(logic [79:0] f, string r);
    for (int i = 79; i >= 0; i--) begin
      shift_bit(f[i]);
      if (i % 16 == 0) push(r);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() > 0) begin
        exp_t  e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        checks++;
        if (en !== e.en || sel !== e.sel || sdo !== e.sdo) begin
          errors++;
          $display("FAIL %s en=%h sel=%h sdo=%b expected en=%h sel=%h sdo=%b",
                   r, en, sel, sdo, e.en, e.sel, e.sdo);
        end
      end
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [79:0] fa, fb;
    idle(3);
    push("R1");                      // R1 during reset
    rst_ni = 1; idle(3);
    push("R1");                      // R1 after reset
    ce_n = 0; idle(4);

    // R2 R3 R4: mixed enables, distinct selects, zero padding
    fa = {5'b1_0111, 5'b0_1010, 5'b1_1111, 5'b1_0000,
          5'b0_0101, 5'b1_1100, 5'b1_0011, 5'b0_1001, 40'h0};
    send_frame(fa, "R3");
    push("R6");                      // R6 outputs wait for strobe
    upd_fall(); push("R4"); upd_rise();

    // R5: nonzero padding must not leak
    fb = {5'b0_0001, 5'b1_1110, 5'b0_0110, 5'b1_1011,
          5'b1_0100, 5'b0_1111, 5'b1_1000, 5'b1_0010, 40'hA5_F0_3C_99_E7};
    send_frame(fb, "R2");
    upd_fall(); push("R5"); upd_rise();
    shift_bit(1'b1); push("R3");

    // R7: parallel write to one address
    par_write(3'd2, 5'b1_0110);
    push("R7");
    upd_fall(); push("R7"); upd_rise();

    // R8: disabled chip ignores everything
    ce_n = 1; idle(4);
    shift_bit(1'b0); shift_bit(1'b1);
    par_write(3'd5, 5'b1_1111);
    upd_fall(); push("R8"); upd_rise();
    ce_n = 0; idle(4);
    upd_fall(); push("R8"); upd_rise();

    // R9: held-low strobe and rising edges do nothing more
    upd_fall();
    par_write(3'd0, 5'b1_1101);
    idle(6); push("R9");
    upd_rise(); push("R9");
    upd_fall(); push("R9"); upd_rise();

    // R1: reset mid-run clears everything
    rst_ni = 0; idle(2);
    m_chain = '0; m_act = '0;
    rst_ni = 1; idle(6);
    push("R1");

    idle(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule